// File: doc/BRIEF.md
# Serial Configuration Word Receiver with Chain Output

This block receives configuration words over a three-wire serial link: a serial clock, a data line and a latch strobe. All three are asynchronous to the block's system clock and are brought into it through two-flop synchronizers. Edges of the serial clock and of the latch strobe are detected on the synchronized levels. The data bit is shifted into a 16-bit register on every rising serial-clock edge, and the level of the latch strobe has no effect on this. Only a rising latch edge hands the register contents to the downstream decoder, as a held word and a pulse that lasts one system clock.

A forwarding output repeats the incoming data 15.5 serial-clock periods later and changes only after falling serial-clock edges. Several receivers can therefore share the serial clock and the latch strobe, each fed from the forwarding output of the one before it. After 16×n clocks, one latch edge commits a word in every device of the chain. The block has no readback path: the forwarding output carries nothing but delayed data. The system clock must run at least eight times faster than the serial clock.

Top module: `cfgser_shifter`

## Requirements
- R1: On each rising serial-clock edge the data bit enters the most significant end of a 16-bit shift register and the register moves one place toward bit 0. This happens whether the latch strobe is high or low. After the last 16 bits, the first of them sits in bit 0 and the last in bit 15. When more than 16 bits are sent, only the last 16 remain.
- R2: A rising latch edge raises `commit_o` for exactly one system clock. In that same cycle `word_o` shows the shift register contents, and `word_o` keeps that value until the next commit.
- R3: A falling latch edge has no effect: `commit_o` stays low and `word_o` stays unchanged. Bits shifted in while the strobe is held high are not committed until the next rising latch edge.
- R4: `sdo_o` carries the bit sampled at one rising serial-clock edge. It appears after the falling edge that follows the 15th later rising edge. Until 16 bits have been received since reset, `sdo_o` is low.
- R5: `sdo_o` changes only after a falling serial-clock edge. Its value across a rising edge is the same as before that edge.
- R6: With two receivers chained (data of the second fed from `sdo_o` of the first), the bench sends 32 bits and then one latch edge. The first receiver commits the last 16 bits sent and the second commits the first 16, in the same cycle.
- R7: While reset is active, `word_o` is zero, `commit_o` is low and `sdo_o` is low. The shift register is cleared, so the first 16 forwarded bits after reset are zero.
- R8: `commit_o` is high in the third system clock after the cycle in which the latch strobe rises (two synchronizer stages, then one register).
- R9: If the last rising serial-clock edge and the rising latch edge are seen in the same system clock, the committed word includes the bit shifted by that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data, least significant bit first |
| slatch_i | input | 1 | Latch strobe, commit on rising edge |
| sdo_o | output | 1 | Forwarded data, SDI delayed 15.5 serial clocks |
| word_o | output | 16 | Last committed word |
| commit_o | output | 1 | One-cycle pulse marking a new committed word |

## Verification
Some behaviour is checked by the assertions on every system clock, measured against the input pins:
- `commit_o` is always a single-cycle pulse.
- A pulse is preceded by a rising latch level at the synchronizer depth.
- `word_o` never moves without a pulse.
- `sdo_o` moves only after a falling serial-clock level.

Other behaviour can be shown only by the bench's scenarios:
- the order in which bits land in the word, and which 16 bits are kept when more are sent;
- the 15.5-clock forwarding delay, checked against a history of every sent bit;
- chaining two receivers;
- a latch edge that arrives in the same cycle as the last serial-clock edge;
- clearing the register in the middle of a word.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;

    localparam int DEF_WORD_W      = 16;
    localparam int DEF_SYNC_STAGES = 2;

    // positions of the asynchronous pins inside the synchronizer vector
    localparam int PIN_SCLK  = 0;
    localparam int PIN_SDI   = 1;
    localparam int PIN_LATCH = 2;
    localparam int PIN_COUNT = 3;

    function automatic logic rise_of(input logic now_v, input logic was_v);
        return now_v & ~was_v;
    endfunction

    function automatic logic fall_of(input logic now_v, input logic was_v);
        return ~now_v & was_v;
    endfunction

endpackage

// File: rtl/cfgser_sync.sv
module cfgser_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/cfgser_shift_core.sv
module cfgser_shift_core
    import cfgser_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdi_s,
    output logic [WORD_W-1:0] shift_next_o,
    output logic              sdo_o
);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic              sclk_prev;
        logic              sdo;
    } core_t;

    core_t core_d, core_q;
    logic  sclk_rise, sclk_fall;

    always_comb begin
        core_d           = core_q;
        sclk_rise        = rise_of(sclk_s, core_q.sclk_prev);
        sclk_fall        = fall_of(sclk_s, core_q.sclk_prev);
        core_d.sclk_prev = sclk_s;
        // new bit enters at the top, so the first bit of a word ends in bit 0
        if (sclk_rise) begin
            core_d.shreg = {sdi_s, core_q.shreg[WORD_W-1:1]};
        end
        // bit 0 has been in the register for WORD_W-1 rises: forward it half a period later
        if (sclk_fall) begin
            core_d.sdo = core_q.shreg[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign shift_next_o = core_d.shreg;
    assign sdo_o        = core_q.sdo;

endmodule

// File: rtl/cfgser_commit.sv
module cfgser_commit
    import cfgser_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_s,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] word_o,
    output logic              commit_o
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              latch_prev;
        logic              pulse;
    } commit_t;

    commit_t cm_d, cm_q;
    logic    latch_rise;

    always_comb begin
        cm_d            = cm_q;
        latch_rise      = rise_of(latch_s, cm_q.latch_prev);
        cm_d.latch_prev = latch_s;
        cm_d.pulse      = latch_rise;
        if (latch_rise) begin
            cm_d.word = word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cm_q <= '0;
        end else begin
            cm_q <= cm_d;
        end
    end

    assign word_o   = cm_q.word;
    assign commit_o = cm_q.pulse;

endmodule

// File: rtl/cfgser_shifter.sv
module cfgser_shifter
    import cfgser_pkg::*;
#(
    parameter int WORD_W      = DEF_WORD_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              slatch_i,
    output logic              sdo_o,
    output logic [WORD_W-1:0] word_o,
    output logic              commit_o
);

    logic [PIN_COUNT-1:0] pins_async;
    logic [PIN_COUNT-1:0] pins_sync;
    logic [WORD_W-1:0]    shift_next;

    always_comb begin
        pins_async            = '0;
        pins_async[PIN_SCLK]  = sclk_i;
        pins_async[PIN_SDI]   = sdi_i;
        pins_async[PIN_LATCH] = slatch_i;
    end

    // data goes through the same depth as the clock so both stay aligned
    cfgser_sync #(
        .W      (PIN_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_async),
        .sync_o  (pins_sync)
    );

    cfgser_shift_core #(
        .WORD_W (WORD_W)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_s       (pins_sync[PIN_SCLK]),
        .sdi_s        (pins_sync[PIN_SDI]),
        .shift_next_o (shift_next),
        .sdo_o        (sdo_o)
    );

    // takes the next-state word, so a rise seen with the latch edge is included
    cfgser_commit #(
        .WORD_W (WORD_W)
    ) u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_s  (pins_sync[PIN_LATCH]),
        .word_i   (shift_next),
        .word_o   (word_o),
        .commit_o (commit_o)
    );

endmodule

// File: rtl/cfgser_shifter_chk.sv
module cfgser_shifter_chk #(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk_i,
    input logic              slatch_i,
    input logic              sdo_o,
    input logic [WORD_W-1:0] word_o,
    input logic              commit_o
);

    localparam int LAT_NOW = SYNC_STAGES + 1;
    localparam int LAT_WAS = SYNC_STAGES + 2;

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o); // R2

    AST_COMMIT_ON_LATCH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> ($past(slatch_i, LAT_NOW) && !$past(slatch_i, LAT_WAS))); // R2

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_o |-> $stable(word_o)); // R3

    AST_SDO_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_o) |-> (!$past(sclk_i, LAT_NOW) && $past(sclk_i, LAT_WAS))); // R5

endmodule

bind cfgser_shifter cfgser_shifter_chk #(
    .WORD_W      (WORD_W),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_i   (sclk_i),
    .slatch_i (slatch_i),
    .sdo_o    (sdo_o),
    .word_o   (word_o),
    .commit_o (commit_o)
);

// File: tb/cfgser_shifter_tb.sv
module cfgser_shifter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        slatch = 1'b0;
    logic        sdo, commit, sdo2, commit2;
    logic [15:0] word, word2;

    int n_chk = 0;
    int n_fail = 0;
    int commit_seen = 0;
    int nbits = 0;
    bit done = 1'b0;
    logic hist [0:4095];

    localparam logic [15:0] VEC [6] = '{16'hA5C3, 16'h0001, 16'h8000,
                                        16'hFFFF, 16'h0000, 16'h1234};

    always #10 clk = ~clk;

    cfgser_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .slatch_i(slatch),
        .sdo_o(sdo), .word_o(word), .commit_o(commit)
    );

    cfgser_shifter u_tail (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdo), .slatch_i(slatch),
        .sdo_o(sdo2), .word_o(word2), .commit_o(commit2)
    );

    always @(negedge clk) if (commit) commit_seen++;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_sdo();
        return (nbits >= 16) ? hist[nbits-16] : 1'b0;
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk);
        sclk = 1'b0;
        sdi  = b;
        repeat (4) @(negedge clk);
        chk(sdo === exp_sdo(), "R4 sdo after falling edge", {31'd0, sdo}, {31'd0, exp_sdo()});
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        chk(sdo === exp_sdo(), "R5 sdo held across rising edge", {31'd0, sdo}, {31'd0, exp_sdo()});
        hist[nbits] = b;
        nbits++;
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 0; i < 16; i++) send_bit(w[i]);
    endtask

    task automatic do_latch(input logic [15:0] exp, input bit tail_chk, input logic [15:0] exp_tail,
                            input string tag);
        int hits = 0;
        int hits2 = 0;
        int at = 0;
        logic [15:0] got = '0;
        logic [15:0] got2 = '0;
        @(negedge clk);
        slatch = 1'b1;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (commit) begin hits++; at = i; got = word; end
            if (commit2) begin hits2++; got2 = word2; end
        end
        chk(hits == 1, "R2 single commit pulse", hits, 1);
        chk(at == 3, "R8 commit latency", at, 3);
        chk(got == exp, {tag, " R1 committed word"}, {16'd0, got}, {16'd0, exp});
        if (tail_chk) begin
            chk(hits2 == 1, "R6 tail commit pulse", hits2, 1);
            chk(got2 == exp_tail, "R6 tail committed word", {16'd0, got2}, {16'd0, exp_tail});
        end
        slatch = 1'b0;
        hits = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (commit) hits++;
        end
        chk(hits == 0, "R3 no commit on falling latch", hits, 0);
        chk(word == exp, "R3 word held after falling latch", {16'd0, word}, {16'd0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R7 reset state
        repeat (3) @(negedge clk);
        chk(word == 16'h0, "R7 reset word", {16'd0, word}, 0);
        chk(commit == 1'b0, "R7 reset commit", {31'd0, commit}, 0);
        chk(sdo == 1'b0, "R7 reset sdo", {31'd0, sdo}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // table of words: R1 ordering, R2 pulse, R4 forwarding of the previous word
        for (int v = 0; v < 6; v++) begin
            send_word(VEC[v]);
            do_latch(VEC[v], 1'b0, 16'h0, "table");
        end

        // R1/R3: shifting continues while latch is held high; no commit until next rise
        begin
            int base;
            @(negedge clk);
            slatch = 1'b1;
            repeat (8) @(negedge clk);
            base = commit_seen;
            send_word(16'h5A0F);
            slatch = 1'b0;
            repeat (8) @(negedge clk);
            chk(commit_seen == base, "R3 no commit while latch high or falling", commit_seen, base);
            chk(word == VEC[5], "R1 word unchanged while shifting under high latch",
                {16'd0, word}, {16'd0, VEC[5]});
            do_latch(16'h5A0F, 1'b0, 16'h0, "held latch");
        end

        // R9: last rising clock edge and latch edge in the same cycle
        begin
            logic [15:0] w = 16'h8C31;
            int hits = 0;
            logic [15:0] got = '0;
            for (int i = 0; i < 15; i++) send_bit(w[i]);
            @(negedge clk);
            sclk = 1'b0;
            sdi  = w[15];
            repeat (4) @(negedge clk);
            sclk   = 1'b1;
            slatch = 1'b1;
            hist[nbits] = w[15];
            nbits++;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (commit) begin hits++; got = word; end
            end
            chk(hits == 1, "R9 one commit with coincident edges", hits, 1);
            chk(got == w, "R9 word includes coincident bit", {16'd0, got}, {16'd0, w});
            slatch = 1'b0;
            repeat (4) @(negedge clk);
        end

        // R6: two chained receivers, 32 bits then one latch edge
        send_word(16'hC3E1);
        send_word(16'h7E18);
        do_latch(16'h7E18, 1'b1, 16'hC3E1, "chain head");

        // R7: reset in mid-word clears everything, forwarded bits restart at zero
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        sclk  = 1'b0;
        sdi   = 1'b0;
        @(negedge clk);
        chk(word == 16'h0, "R7 word cleared by reset", {16'd0, word}, 0);
        chk(word2 == 16'h0, "R7 tail word cleared by reset", {16'd0, word2}, 0);
        chk(commit == 1'b0, "R7 commit low in reset", {31'd0, commit}, 0);
        chk(sdo == 1'b0 && sdo2 == 1'b0, "R7 sdo low in reset", {30'd0, sdo2, sdo}, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        nbits = 0;
        repeat (3) @(negedge clk);
        send_word(16'h0F0F);
        do_latch(16'h0F0F, 1'b0, 16'h0, "after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule